// File: doc/BRIEF.md
# Two-Wire EEPROM Serial Front End

This block is the bus side of a small two-wire serial EEPROM. It runs on a fast system clock and oversamples the clock line and the data line. Each line goes through a two-stage synchronizer and a run-length glitch filter. The block then recognises bus start and stop conditions. It shifts bytes in on clock rises and drives data out after clock falls, through an open-drain style pull-down output.

The first byte after a start condition is the device-select byte. Its upper nibble must equal the device code `1010`, and its lowest bit gives the direction. The middle bits depend on the array size. In the narrow (1K-word) mode, one bit is compared with a strap pin and two bits become high word-address bits. In the wide (2K-word) mode, all three bits become high word-address bits and no strap compare is made. A transaction controller behind this block receives the accepted select information and the write bytes. It also supplies read bytes when asked. The memory array, write buffering and the address counter live in that controller.

Top module: `ee_serial_front`

## Requirements
- R1: A start is a data fall while the clock is high, and a stop is a data rise while the clock is high. Both are recognised in every state. Nothing is acknowledged until a start has been seen. A stop releases the data line, returns to idle and pulses `stop_o` once.
- R2: Data bits are sampled on clock rises, most significant bit first.
- R3: A select byte is accepted only when bits 7:4 equal `1010`. Bit 0 gives the direction, where 0 is write and 1 is read, and it is reported on `sel_read_o`.
- R4: With `wide_mode_i`=0, bit 3 of the select byte must equal `strap_a2_i`. Bits 2:1 appear on `page_o[1:0]`, and `page_o[2]` is 0.
- R5: With `wide_mode_i`=1, bits 3:1 of the select byte appear on `page_o[2:0]`, and `strap_a2_i` has no effect.
- R6: The block pulls the data line low for the ninth clock after an accepted select byte and after every byte received in a write. Each write byte is reported by a one-cycle `wr_valid_o` with the value on `wr_data_o`.
- R7: A select byte that does not match gets no acknowledge. All later bytes are ignored, with no acknowledge and no `wr_valid_o`, until the next start.
- R8: In a read, `rd_data_i` is sampled on the clock fall that begins each byte, and a one-cycle `rd_take_o` follows. The byte is sent most significant bit first, and the pull-down output changes only after a clock fall or a bus condition.
- R9: During a read the line is released on the ninth clock, and the master's bit is sampled there. Low sends the next byte. High ends sending, so the line stays released and `rd_take_o` stays low until a start or a stop.
- R10: A pulse on either line that is shorter than `FILT_LEN` system clocks has no effect. This holds for a false start and for an extra clock edge.
- R11: A start in the middle of a transfer clears the bit position and begins a new select-byte phase.
- R12: After reset the pull-down output and all pulse outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pull_o | output | 1 | 1 pulls the data line low (open-drain enable) |
| strap_a2_i | input | 1 | Chip-select strap compared in narrow mode |
| wide_mode_i | input | 1 | 0 selects the 1K-word decode, 1 the 2K-word decode |
| sel_valid_o | output | 1 | One-cycle pulse: select byte accepted |
| sel_read_o | output | 1 | Direction of the last accepted select byte |
| page_o | output | 3 | High word-address bits from the select byte |
| wr_valid_o | output | 1 | One-cycle pulse: write byte received |
| wr_data_o | output | 8 | Last received write byte |
| rd_take_o | output | 1 | One-cycle pulse: read byte taken from `rd_data_i` |
| rd_data_i | input | 8 | Next byte to send in a read |
| stop_o | output | 1 | One-cycle pulse on a stop condition |

## Verification
The assertions assume a bus that never has its data line changed by the master while the clock is high, except to form a start or a stop. They also assume that every clock high and low phase outlasts the synchronizer plus filter latency. The bench meets both assumptions with bit-banged phases of five system clocks, which is longer than the filter window. Its only deliberate violations are glitches of two clocks, shorter than the window. `wide_mode_i` and `strap_a2_i` are changed only while the bus is idle between transactions, so the decode seen at each select byte matches the settings the bench used to compute its expectation.

// File: rtl/ee_serial_front_pkg.sv
package ee_serial_front_pkg;
  localparam int BYTE_W  = 8;
  localparam int PAGE_W  = 3;
  localparam int CNT_W   = $clog2(BYTE_W + 1);
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_WR,
    ST_RD,
    ST_HOLD
  } fe_state_t;
endpackage

// File: rtl/ee_line_filter.sv
module ee_line_filter #(
  parameter int   FILT_LEN = 4,
  parameter logic IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;
  logic          line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= {2{IDLE_VAL}};
      run_q  <= '0;
      line_q <= IDLE_VAL;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] == line_q) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_LEN - 1)) begin
        line_q <= sync_q[1];
        run_q  <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign line_o = line_q;

  AST_FILT_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (rst)
    !$stable(line_q) |-> line_q == $past(sync_q[1])); // R10
endmodule

// File: rtl/ee_bus_events.sv
module ee_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic cond_start,
  output logic cond_stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise   = scl_f & ~scl_q;
  assign scl_fall   = ~scl_f & scl_q;
  assign cond_start = scl_f & scl_q & sda_q & ~sda_f;
  assign cond_stop  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/ee_serial_front.sv
module ee_serial_front
  import ee_serial_front_pkg::*;
#(
  parameter int FILT_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic              strap_a2_i,
  input  logic              wide_mode_i,
  output logic              sel_valid_o,
  output logic              sel_read_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              wr_valid_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_take_o,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              stop_o
);
  logic [1:0] raw_lines, filt_lines;
  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    ee_line_filter #(.FILT_LEN(FILT_LEN), .IDLE_VAL(1'b1)) u_filt (
      .clk(clk), .rst(rst), .raw_i(raw_lines[g]), .line_o(filt_lines[g]));
  end

  logic scl_f, sda_f;
  assign scl_f = filt_lines[0];
  assign sda_f = filt_lines[1];

  logic ev_rise, ev_fall, ev_start, ev_stop;
  ee_bus_events u_events (
    .clk(clk), .rst(rst), .scl_f(scl_f), .sda_f(sda_f),
    .scl_rise(ev_rise), .scl_fall(ev_fall),
    .cond_start(ev_start), .cond_stop(ev_stop));

  fe_state_t         state_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic              in_ack_q, pull_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [BYTE_W-2:0] tx_q;
  logic              sel_valid_q, sel_read_q, wr_valid_q, rd_take_q, stop_q;
  logic [PAGE_W-1:0] page_q;
  logic [BYTE_W-1:0] wr_data_q;

  logic              byte_done, sel_match;
  logic [PAGE_W-1:0] page_nxt;

  assign byte_done = (bit_cnt_q == CNT_W'(BYTE_W));
  assign sel_match = (shreg_q[7:4] == DEV_CODE) &&
                     (wide_mode_i || (shreg_q[3] == strap_a2_i));
  assign page_nxt  = wide_mode_i ? shreg_q[3:1] : {1'b0, shreg_q[2:1]};

  always_ff @(posedge clk) begin
    sel_valid_q <= 1'b0;
    wr_valid_q  <= 1'b0;
    rd_take_q   <= 1'b0;
    stop_q      <= 1'b0;
    if (rst) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      in_ack_q   <= 1'b0;
      pull_q     <= 1'b0;
      shreg_q    <= '0;
      tx_q       <= '0;
      sel_read_q <= 1'b0;
      page_q     <= '0;
      wr_data_q  <= '0;
    end else if (ev_start) begin
      state_q   <= ST_SEL;
      bit_cnt_q <= '0;
      in_ack_q  <= 1'b0;
      pull_q    <= 1'b0;
    end else if (ev_stop) begin
      state_q  <= ST_IDLE;
      in_ack_q <= 1'b0;
      pull_q   <= 1'b0;
      stop_q   <= 1'b1;
    end else begin
      unique case (state_q)
        ST_SEL, ST_WR: begin
          if (ev_rise && !in_ack_q && !byte_done) begin
            shreg_q   <= {shreg_q[BYTE_W-2:0], sda_f};
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end else if (ev_fall && in_ack_q) begin
            in_ack_q  <= 1'b0;
            bit_cnt_q <= '0;
            pull_q    <= 1'b0;
            if (state_q == ST_SEL && sel_read_q) begin
              state_q   <= ST_RD;
              tx_q      <= rd_data_i[BYTE_W-2:0];
              pull_q    <= ~rd_data_i[BYTE_W-1];
              rd_take_q <= 1'b1;
            end else begin
              state_q <= ST_WR;
            end
          end else if (ev_fall && byte_done) begin
            if (state_q == ST_SEL) begin
              if (sel_match) begin
                in_ack_q    <= 1'b1;
                pull_q      <= 1'b1;
                sel_valid_q <= 1'b1;
                sel_read_q  <= shreg_q[0];
                page_q      <= page_nxt;
              end else begin
                state_q <= ST_IDLE;
              end
            end else begin
              in_ack_q   <= 1'b1;
              pull_q     <= 1'b1;
              wr_valid_q <= 1'b1;
              wr_data_q  <= shreg_q;
            end
          end
        end
        ST_RD: begin
          if (ev_rise && !in_ack_q && !byte_done) begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end else if (ev_rise && in_ack_q && sda_f) begin
            state_q <= ST_HOLD;
          end else if (ev_fall && in_ack_q) begin
            in_ack_q  <= 1'b0;
            bit_cnt_q <= '0;
            tx_q      <= rd_data_i[BYTE_W-2:0];
            pull_q    <= ~rd_data_i[BYTE_W-1];
            rd_take_q <= 1'b1;
          end else if (ev_fall && byte_done) begin
            pull_q   <= 1'b0;
            in_ack_q <= 1'b1;
          end else if (ev_fall) begin
            pull_q <= ~tx_q[BYTE_W-2];
            tx_q   <= {tx_q[BYTE_W-3:0], 1'b0};
          end
        end
        default: begin
          pull_q   <= 1'b0;
          in_ack_q <= 1'b0;
        end
      endcase
    end
  end

  assign sda_pull_o  = pull_q;
  assign sel_valid_o = sel_valid_q;
  assign sel_read_o  = sel_read_q;
  assign page_o      = page_q;
  assign wr_valid_o  = wr_valid_q;
  assign wr_data_o   = wr_data_q;
  assign rd_take_o   = rd_take_q;
  assign stop_o      = stop_q;

  AST_PULL_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull_o) |-> $past(ev_fall || ev_start || ev_stop)); // R8
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
    ev_stop |=> !sda_pull_o && stop_o); // R1
  AST_NARROW_PAGE_TOP: assert property (@(posedge clk) disable iff (rst)
    sel_valid_o && !$past(wide_mode_i) |-> !page_o[PAGE_W-1]); // R4
  AST_WRITE_DIR_ONLY: assert property (@(posedge clk) disable iff (rst)
    wr_valid_o |-> !sel_read_o); // R6
  AST_TAKE_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
    rd_take_o |-> sel_read_o); // R8
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_HOLD && !ev_start |=> !rd_take_o && !sda_pull_o); // R9
endmodule

// File: tb/ee_serial_front_bench.sv
`timescale 1ns/1ps
module ee_serial_front_bench;
  localparam int Q = 5;

  logic clk = 1'b0;
  logic rst, scl_m, sda_m, strap, wide;
  logic pull, sel_valid, sel_read, wr_valid, rd_take, stop_p;
  logic [2:0] page;
  logic [7:0] wr_data, rd_data;
  logic line;

  int n_chk = 0, n_fail = 0;
  int n_sel = 0, n_wr = 0, n_take = 0, n_stop = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign line    = sda_m & ~pull;
  assign rd_data = 8'hA7 ^ (8'(n_take) * 8'h1D);

  ee_serial_front u_ee_serial_front (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(line), .sda_pull_o(pull),
    .strap_a2_i(strap), .wide_mode_i(wide), .sel_valid_o(sel_valid),
    .sel_read_o(sel_read), .page_o(page), .wr_valid_o(wr_valid),
    .wr_data_o(wr_data), .rd_take_o(rd_take), .rd_data_i(rd_data),
    .stop_o(stop_p));

  always @(posedge clk) begin
    if (sel_valid) n_sel <= n_sel + 1;
    if (wr_valid)  n_wr  <= n_wr + 1;
    if (rd_take)   n_take <= n_take + 1;
    if (stop_p)    n_stop <= n_stop + 1;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rd_val(input int k);
    return 8'hA7 ^ (8'(k) * 8'h1D);
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2 * Q);
  endtask

  task automatic bit_out(input logic b, input bit glitch);
    sda_m = b; tick(Q); scl_m = 1'b1;
    if (glitch) begin
      tick(4); scl_m = 1'b0; tick(2); scl_m = 1'b1; tick(4);
    end else begin
      tick(2 * Q);
    end
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit acked);
    for (int i = 7; i >= 0; i--) bit_out(b[i], glitch);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    acked = !line;
    tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(Q); scl_m = 1'b1; tick(Q);
      d = {d[6:0], line};
      tick(Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = nack; tick(Q); scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0; tick(Q); sda_m = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] d;
    int s0, base;
    rst = 1'b1; scl_m = 1'b1; sda_m = 1'b1; strap = 1'b0; wide = 1'b1;
    tick(10);
    chk("R12 reset pull", int'(pull), 0);
    chk("R12 reset pulses", int'({sel_valid, wr_valid, rd_take, stop_p}), 0);
    rst = 1'b0;
    tick(10);
    chk("R12 idle pull", int'(pull), 0);

    // R1: no start seen, select byte ignored
    s0 = n_sel;
    scl_m = 1'b0; tick(Q);
    send_byte(8'hA0, 1'b0, ack);
    chk("R1 no ack without start", int'(ack), 0);
    chk("R1 no select without start", n_sel - s0, 0);
    bus_stop();

    // R10: short data glitch while clock high is no start
    sda_m = 1'b0; tick(2); sda_m = 1'b1; tick(Q);
    scl_m = 1'b0; tick(Q);
    send_byte(8'hA0, 1'b0, ack);
    chk("R10 false start rejected", int'(ack), 0);
    bus_stop();

    // R5/R6/R2/R10: write with page in wide mode
    bus_start();
    send_byte(8'hA6, 1'b0, ack);
    chk("R6 select ack", int'(ack), 1);
    chk("R5 page wide", int'(page), 3);
    chk("R3 write dir", int'(sel_read), 0);
    s0 = n_wr;
    send_byte(8'h5A, 1'b0, ack);
    chk("R6 data ack", int'(ack), 1);
    chk("R2 write byte", int'(wr_data), 8'h5A);
    send_byte(8'hC3, 1'b1, ack);
    chk("R10 clock glitch ack", int'(ack), 1);
    chk("R10 clock glitch byte", int'(wr_data), 8'hC3);
    chk("R6 write pulses", n_wr - s0, 2);
    s0 = n_stop;
    bus_stop();
    chk("R1 stop pulse", n_stop - s0, 1);
    chk("R1 released after stop", int'(pull), 0);

    // R7: mismatch then data ignored
    bus_start();
    s0 = n_wr;
    send_byte(8'h90, 1'b0, ack);
    chk("R7 mismatch nack", int'(ack), 0);
    send_byte(8'h11, 1'b0, ack);
    chk("R7 later byte nack", int'(ack), 0);
    chk("R7 no write pulse", n_wr - s0, 0);
    bus_stop();

    // R8/R9: sequential read
    bus_start();
    send_byte(8'hA1, 1'b0, ack);
    chk("R3 read select ack", int'(ack), 1);
    chk("R3 read dir", int'(sel_read), 1);
    base = n_take;
    for (int k = 0; k < 3; k++) begin
      recv_byte(k == 2, d);
      chk("R8 read byte", int'(d), int'(rd_val(base + k)));
    end
    chk("R8 take pulses", n_take - base, 3);
    for (int i = 0; i < 9; i++) begin
      tick(Q); scl_m = 1'b1; tick(Q);
      chk("R9 released after nack", int'(line), 1);
      tick(Q); scl_m = 1'b0; tick(Q);
    end
    chk("R9 no more takes", n_take - base, 3);
    bus_stop();

    // R11: repeated start mid byte
    bus_start();
    bit_out(1'b1, 1'b0); bit_out(1'b0, 1'b0); bit_out(1'b1, 1'b0);
    bus_start();
    s0 = n_sel;
    send_byte(8'hA5, 1'b0, ack);
    chk("R11 ack after restart", int'(ack), 1);
    chk("R11 one select", n_sel - s0, 1);
    chk("R11 page", int'(page), 2);
    chk("R11 dir", int'(sel_read), 1);
    base = n_take;
    recv_byte(1'b1, d);
    chk("R8 read after restart", int'(d), int'(rd_val(base)));
    bus_stop();

    // R3/R4/R5 sweep of all select bytes in both modes
    for (int m = 0; m < 2; m++) begin
      for (int b = 0; b < 256; b++) begin
        logic [7:0] sb;
        bit match;
        sb = 8'(b);
        wide = m[0];
        strap = sb[0] ^ sb[4] ^ m[0];
        tick(2);
        match = (sb[7:4] == 4'b1010) && (wide || sb[3] == strap);
        s0 = n_sel;
        bus_start();
        send_byte(sb, 1'b0, ack);
        chk(wide ? "R5 sweep ack" : "R4 sweep ack", int'(ack), int'(match));
        chk("R3 sweep select count", n_sel - s0, int'(match));
        if (match) begin
          chk(wide ? "R5 sweep page" : "R4 sweep page", int'(page),
              wide ? int'(sb[3:1]) : int'(sb[2:1]));
          chk("R3 sweep dir", int'(sel_read), int'(sb[0]));
          if (sb[0]) recv_byte(1'b1, d);
        end
        bus_stop();
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule